// File: doc/BRIEF.md
# Per-Lane Memory Segment Address Generator

This unit sits in the memory-issue path of a SIMD core. It accepts one vector memory request per handshake. The request carries a per-lane active mask, a segment-relative address for each lane, a segment code, an access size, an operation (load, store or atomic) and the base and size values of the issuing wavefront. For each lane it forms the physical address with a formula chosen by the segment. It flags lanes whose address breaks the segment's limits. It then presents the request, registered, to either the global or the local memory queue, together with a fixed latency for that class of access.

Argument segments never reach a queue. They produce a single uniform address, taken from the lowest active lane, on a separate one-cycle bypass output. Segment and operation pairs that cannot be served produce a one-cycle error pulse and issue nothing.

Four counters track outstanding traffic: global reads, global writes, local reads and local writes. They rise when a request is handed to a queue and fall on completion pulses.

Top module: `lane_seg_agen`

## Requirements
- R1: A lane whose mask bit is 0 leaves with its input address unchanged and its fault bit clear, whatever the segment.
- R2: Segment code 0 (global): an active lane with address a below priv_size is redirected to (a>>3)*8*LANES + lane*8 + (a&7) + priv_base. Such a lane faults if a is not a multiple of the access size, or if the result is at or above priv_base + priv_size*LANES. Other lanes keep a, with no fault.
- R3: Segment code 2 (spill): an active lane becomes a*spill_stride + lane*size + spill_base, and faults when a >= spill_size.
- R4: Segment code 3 (read-only): an active lane becomes a + ro_base, and faults when a + size > ro_size.
- R5: Segment code 1 (private): an active lane becomes a + lane*size + priv_base, and faults when a >= priv_size.
- R6: Segment code 4 (group) keeps addresses unchanged and goes to the local pipe (out_pipe=1) with latency 24. Every other issued request goes to the global pipe (out_pipe=0). A global request has latency 64 when it is an atomic and 1 otherwise. Access size is 1<<in_size_log2 bytes. Operation codes are 0 load, 1 store, 2 atomic.
- R7: The following requests raise err_valid for one cycle and issue no request and no bypass:
  - an atomic outside codes 0 and 4;
  - a store to code 3;
  - a code 2 access with in_nregs not 1;
  - a store or atomic to code 5;
  - an atomic to code 6;
  - any request with code 7.
- R8: Codes 5 (kernel arguments) and 6 (call arguments) raise byp_valid for one cycle, with byp_addr equal to the address of the lowest-indexed active lane, or 0 when no lane is active. No queue request is issued.
- R9: An issued request holds out_valid and all of its fields stable until the ready input of its own pipe is high. The other pipe's ready has no effect.
- R10: in_ready is high when the output register is empty or is being emptied in the same cycle. An accepted request appears on the outputs in the next cycle.
- R11: When a request is handed over, its pipe's read counter rises for a load or atomic, and its write counter rises for a store or atomic. Each counter falls by one on its completion pulse. Both in one cycle leave it unchanged.
- R12: During and after reset, out_valid, err_valid and byp_valid are 0, in_ready is 1 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_mask | input | LANES | Per-lane active mask |
| in_addr | input | LANES*AW | Segment-relative address per lane, lane 0 in the low bits |
| in_seg | input | 3 | Segment code |
| in_op | input | 2 | 0 load, 1 store, 2 atomic |
| in_size_log2 | input | 2 | log2 of access size in bytes |
| in_nregs | input | 3 | Register count of the access |
| priv_base | input | AW | Private space base |
| priv_size | input | AW | Private bytes per lane |
| spill_base | input | AW | Spill space base |
| spill_size | input | AW | Spill limit per lane |
| spill_stride | input | AW | Spill row width multiplier |
| ro_base | input | AW | Read-only space base |
| ro_size | input | AW | Read-only space size |
| out_valid | output | 1 | Queue request present |
| out_pipe | output | 1 | 0 global queue, 1 local queue |
| out_latency | output | 7 | Assigned latency |
| out_op | output | 2 | Operation of the request |
| out_mask | output | LANES | Active mask of the request |
| out_addr | output | LANES*AW | Physical address per lane |
| out_fault | output | LANES | Per-lane fault flags |
| rdy_glb | input | 1 | Global queue ready |
| rdy_loc | input | 1 | Local queue ready |
| err_valid | output | 1 | Rejected request pulse |
| byp_valid | output | 1 | Argument bypass pulse |
| byp_addr | output | AW | Uniform bypass address |
| cpl_glb_rd | input | 1 | Global read completion |
| cpl_glb_wr | input | 1 | Global write completion |
| cpl_loc_rd | input | 1 | Local read completion |
| cpl_loc_wr | input | 1 | Local write completion |
| cnt_glb_rd | output | CNT_W | Outstanding global reads |
| cnt_glb_wr | output | CNT_W | Outstanding global writes |
| cnt_loc_rd | output | CNT_W | Outstanding local reads |
| cnt_loc_wr | output | CNT_W | Outstanding local writes |

## Verification
Some properties are checked on every cycle:
- the output holds while its own pipe stalls, and in_ready stays low then;
- inactive lanes never carry a fault;
- local and global-atomic latencies are correct;
- error pulses never coincide with a request or a bypass;
- counters move by at most one per cycle, and both global counters rise on a global atomic hand-over;
- the state is quiet after reset.

The per-segment address formulas, the fault thresholds at their exact edges, the lowest-active-lane choice for bypass and the absolute counter totals are shown only by the bench. The bench uses hand-computed vectors for those.

// File: rtl/lseg_pkg.sv
package lseg_pkg;

    localparam int LAT_W   = 7;
    localparam int NUM_CNT = 4;

    localparam logic [LAT_W-1:0] LAT_LOCAL      = 7'd24;
    localparam logic [LAT_W-1:0] LAT_GLOBAL     = 7'd1;
    localparam logic [LAT_W-1:0] LAT_GLB_ATOMIC = 7'd64;

    // counter slots
    localparam int CNT_GLB_RD = 0;
    localparam int CNT_GLB_WR = 1;
    localparam int CNT_LOC_RD = 2;
    localparam int CNT_LOC_WR = 3;

    typedef enum logic [2:0] {
        SEG_GLOBAL  = 3'd0,
        SEG_PRIVATE = 3'd1,
        SEG_SPILL   = 3'd2,
        SEG_RDONLY  = 3'd3,
        SEG_GROUP   = 3'd4,
        SEG_KARG    = 3'd5,
        SEG_CARG    = 3'd6,
        SEG_NONE    = 3'd7
    } seg_e;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_ATOMIC = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        K_REQ = 2'd0,
        K_ERR = 2'd1,
        K_BYP = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic             pipe;
        logic [LAT_W-1:0] lat;
    } route_t;

    function automatic logic op_reads(input op_e op);
        return (op == OP_LOAD) || (op == OP_ATOMIC);
    endfunction

    function automatic logic op_writes(input op_e op);
        return (op == OP_STORE) || (op == OP_ATOMIC);
    endfunction

endpackage

// File: rtl/lseg_lane_xlate.sv
module lseg_lane_xlate
    import lseg_pkg::*;
#(
    parameter int AW       = 32,
    parameter int LANES    = 4,
    parameter int LANE_IDX = 0
) (
    input  logic          active,
    input  logic [AW-1:0] addr_i,
    input  seg_e          seg,
    input  logic [1:0]    size_log2,
    input  logic [AW-1:0] priv_base,
    input  logic [AW-1:0] priv_size,
    input  logic [AW-1:0] spill_base,
    input  logic [AW-1:0] spill_size,
    input  logic [AW-1:0] spill_stride,
    input  logic [AW-1:0] ro_base,
    input  logic [AW-1:0] ro_size,
    output logic [AW-1:0] addr_o,
    output logic          fault_o
);
    localparam logic [AW-1:0] ROW_BYTES  = AW'(8 * LANES);
    localparam logic [AW-1:0] LANE_SLOT8 = AW'(8 * LANE_IDX);
    localparam logic [AW-1:0] LANE_NUM   = AW'(LANE_IDX);
    localparam logic [AW-1:0] LANE_CNT   = AW'(LANES);

    logic [AW-1:0] size_bytes;
    logic [AW-1:0] lane_off;
    logic [AW-1:0] priv_lin;
    logic [AW-1:0] priv_ilv;
    logic [AW-1:0] priv_end;
    logic [AW-1:0] spill_addr;
    logic          below_priv;
    logic          misalign;

    always_comb begin
        size_bytes = AW'(1) << size_log2;
        lane_off   = LANE_NUM << size_log2;
        priv_lin   = addr_i + lane_off + priv_base;
        priv_ilv   = ((addr_i >> 3) * ROW_BYTES) + LANE_SLOT8
                     + (addr_i & AW'(7)) + priv_base;
        priv_end   = priv_base + (priv_size * LANE_CNT);
        spill_addr = (addr_i * spill_stride) + lane_off + spill_base;
        below_priv = addr_i < priv_size;
        misalign   = ((size_bytes - AW'(1)) & addr_i) != '0;
    end

    always_comb begin
        addr_o  = addr_i;
        fault_o = 1'b0;
        if (active) begin
            unique case (seg)
                SEG_GLOBAL: begin
                    if (below_priv) begin
                        addr_o  = priv_ilv;
                        fault_o = misalign || (priv_ilv >= priv_end);
                    end
                end
                SEG_PRIVATE: begin
                    addr_o  = priv_lin;
                    fault_o = !below_priv;
                end
                SEG_SPILL: begin
                    addr_o  = spill_addr;
                    fault_o = addr_i >= spill_size;
                end
                SEG_RDONLY: begin
                    addr_o  = addr_i + ro_base;
                    fault_o = (addr_i + size_bytes) > ro_size;
                end
                default: begin
                    addr_o  = addr_i;
                    fault_o = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/lseg_route.sv
module lseg_route
    import lseg_pkg::*;
(
    input  seg_e       seg,
    input  op_e        op,
    input  logic [2:0] nregs,
    output route_t     route
);
    logic bad;

    always_comb begin
        bad = 1'b0;
        if (op == OP_RSVD) bad = 1'b1;
        unique case (seg)
            SEG_GLOBAL, SEG_GROUP: ;
            SEG_PRIVATE:           if (op == OP_ATOMIC) bad = 1'b1;
            SEG_SPILL:             if (op == OP_ATOMIC || nregs != 3'd1) bad = 1'b1;
            SEG_RDONLY:            if (op != OP_LOAD) bad = 1'b1;
            SEG_KARG:              if (op != OP_LOAD) bad = 1'b1;
            SEG_CARG:              if (op == OP_ATOMIC) bad = 1'b1;
            default:               bad = 1'b1;
        endcase

        route.pipe = (seg == SEG_GROUP);
        if (seg == SEG_GROUP)
            route.lat = LAT_LOCAL;
        else if (op == OP_ATOMIC)
            route.lat = LAT_GLB_ATOMIC;
        else
            route.lat = LAT_GLOBAL;

        if (bad)
            route.kind = K_ERR;
        else if (seg == SEG_KARG || seg == SEG_CARG)
            route.kind = K_BYP;
        else
            route.kind = K_REQ;
    end

endmodule

// File: rtl/lseg_outst_cnt.sv
module lseg_outst_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (inc && !dec)
            cnt <= cnt + 1'b1;
        else if (dec && !inc)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/lane_seg_agen.sv
module lane_seg_agen
    import lseg_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 32,
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [LANES-1:0]      in_mask,
    input  logic [LANES*AW-1:0]   in_addr,
    input  logic [2:0]            in_seg,
    input  logic [1:0]            in_op,
    input  logic [1:0]            in_size_log2,
    input  logic [2:0]            in_nregs,
    input  logic [AW-1:0]         priv_base,
    input  logic [AW-1:0]         priv_size,
    input  logic [AW-1:0]         spill_base,
    input  logic [AW-1:0]         spill_size,
    input  logic [AW-1:0]         spill_stride,
    input  logic [AW-1:0]         ro_base,
    input  logic [AW-1:0]         ro_size,
    output logic                  out_valid,
    output logic                  out_pipe,
    output logic [6:0]            out_latency,
    output logic [1:0]            out_op,
    output logic [LANES-1:0]      out_mask,
    output logic [LANES*AW-1:0]   out_addr,
    output logic [LANES-1:0]      out_fault,
    input  logic                  rdy_glb,
    input  logic                  rdy_loc,
    output logic                  err_valid,
    output logic                  byp_valid,
    output logic [AW-1:0]         byp_addr,
    input  logic                  cpl_glb_rd,
    input  logic                  cpl_glb_wr,
    input  logic                  cpl_loc_rd,
    input  logic                  cpl_loc_wr,
    output logic [CNT_W-1:0]      cnt_glb_rd,
    output logic [CNT_W-1:0]      cnt_glb_wr,
    output logic [CNT_W-1:0]      cnt_loc_rd,
    output logic [CNT_W-1:0]      cnt_loc_wr
);
    localparam int VW = LANES * AW;

    seg_e           seg_in;
    op_e            op_in;
    route_t         route_d;
    logic [VW-1:0]  xaddr_d;
    logic [LANES-1:0] xfault_d;
    logic [AW-1:0]  uni_addr_d;

    assign seg_in = seg_e'(in_seg);
    assign op_in  = op_e'(in_op);

    // per-lane translation
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lseg_lane_xlate #(
            .AW       (AW),
            .LANES    (LANES),
            .LANE_IDX (g)
        ) u_xlate (
            .active       (in_mask[g]),
            .addr_i       (in_addr[g*AW +: AW]),
            .seg          (seg_in),
            .size_log2    (in_size_log2),
            .priv_base    (priv_base),
            .priv_size    (priv_size),
            .spill_base   (spill_base),
            .spill_size   (spill_size),
            .spill_stride (spill_stride),
            .ro_base      (ro_base),
            .ro_size      (ro_size),
            .addr_o       (xaddr_d[g*AW +: AW]),
            .fault_o      (xfault_d[g])
        );
    end

    lseg_route u_route (
        .seg   (seg_in),
        .op    (op_in),
        .nregs (in_nregs),
        .route (route_d)
    );

    // uniform address from the lowest active lane
    always_comb begin
        uni_addr_d = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (in_mask[i]) uni_addr_d = in_addr[i*AW +: AW];
        end
    end

    // output register
    logic             full_q;
    route_t           route_q;
    op_e              op_q;
    logic [LANES-1:0] mask_q;
    logic [VW-1:0]    addr_q;
    logic [LANES-1:0] fault_q;
    logic [AW-1:0]    uni_q;
    logic             sel_ready;
    logic             consume;
    logic             take;
    logic             issue;

    assign sel_ready = route_q.pipe ? rdy_loc : rdy_glb;
    assign consume   = full_q && ((route_q.kind != K_REQ) || sel_ready);
    assign in_ready  = !full_q || consume;
    assign take      = in_valid && in_ready;
    assign issue     = full_q && (route_q.kind == K_REQ) && sel_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q  <= 1'b0;
            route_q <= '{kind: K_REQ, pipe: 1'b0, lat: '0};
            op_q    <= OP_LOAD;
            mask_q  <= '0;
            addr_q  <= '0;
            fault_q <= '0;
            uni_q   <= '0;
        end else if (take) begin
            full_q  <= 1'b1;
            route_q <= route_d;
            op_q    <= op_in;
            mask_q  <= in_mask;
            addr_q  <= xaddr_d;
            fault_q <= xfault_d;
            uni_q   <= uni_addr_d;
        end else if (consume) begin
            full_q  <= 1'b0;
        end
    end

    assign out_valid   = full_q && (route_q.kind == K_REQ);
    assign err_valid   = full_q && (route_q.kind == K_ERR);
    assign byp_valid   = full_q && (route_q.kind == K_BYP);
    assign out_pipe    = route_q.pipe;
    assign out_latency = route_q.lat;
    assign out_op      = op_q;
    assign out_mask    = mask_q;
    assign out_addr    = addr_q;
    assign out_fault   = fault_q;
    assign byp_addr    = uni_q;

    // outstanding counters
    logic [NUM_CNT-1:0] cnt_inc;
    logic [NUM_CNT-1:0] cnt_dec;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];

    always_comb begin
        cnt_inc[CNT_GLB_RD] = issue && !route_q.pipe && op_reads(op_q);
        cnt_inc[CNT_GLB_WR] = issue && !route_q.pipe && op_writes(op_q);
        cnt_inc[CNT_LOC_RD] = issue &&  route_q.pipe && op_reads(op_q);
        cnt_inc[CNT_LOC_WR] = issue &&  route_q.pipe && op_writes(op_q);
        cnt_dec[CNT_GLB_RD] = cpl_glb_rd;
        cnt_dec[CNT_GLB_WR] = cpl_glb_wr;
        cnt_dec[CNT_LOC_RD] = cpl_loc_rd;
        cnt_dec[CNT_LOC_WR] = cpl_loc_wr;
    end

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        lseg_outst_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .inc (cnt_inc[c]),
            .dec (cnt_dec[c]),
            .cnt (cnt_val[c])
        );
    end

    assign cnt_glb_rd = cnt_val[CNT_GLB_RD];
    assign cnt_glb_wr = cnt_val[CNT_GLB_WR];
    assign cnt_loc_rd = cnt_val[CNT_LOC_RD];
    assign cnt_loc_wr = cnt_val[CNT_LOC_WR];

endmodule

// File: rtl/lseg_chk.sv
module lseg_chk #(
    parameter int LANES = 4,
    parameter int AW    = 32,
    parameter int CNT_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_pipe,
    input logic [6:0]          out_latency,
    input logic [1:0]          out_op,
    input logic [LANES-1:0]    out_mask,
    input logic [LANES*AW-1:0] out_addr,
    input logic [LANES-1:0]    out_fault,
    input logic                rdy_glb,
    input logic                rdy_loc,
    input logic                err_valid,
    input logic                byp_valid,
    input logic                cpl_glb_rd,
    input logic                cpl_glb_wr,
    input logic [CNT_W-1:0]    cnt_glb_rd,
    input logic [CNT_W-1:0]    cnt_glb_wr
);
    logic sel_ready;
    assign sel_ready = out_pipe ? rdy_loc : rdy_glb;

    assert_inactive_clear_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_fault & ~out_mask) == '0));

    assert_local_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_pipe) |-> (out_latency == 7'd24));

    assert_atomic_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_pipe && out_op == 2'd2) |-> (out_latency == 7'd64));

    assert_err_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (!out_valid && !byp_valid));

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !sel_ready) |=> (out_valid && $stable(out_addr)
                                       && $stable(out_pipe) && $stable(out_fault)));

    assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !sel_ready) |-> !in_ready);

    assert_cnt_step_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cnt_glb_rd == $past(cnt_glb_rd))
               || (cnt_glb_rd == CNT_W'($past(cnt_glb_rd) + 1'b1))
               || (cnt_glb_rd == CNT_W'($past(cnt_glb_rd) - 1'b1))));

    assert_atomic_both_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_pipe && rdy_glb && out_op == 2'd2 && !cpl_glb_rd && !cpl_glb_wr)
        |=> ((cnt_glb_rd == CNT_W'($past(cnt_glb_rd) + 1'b1))
          && (cnt_glb_wr == CNT_W'($past(cnt_glb_wr) + 1'b1))));

    assert_reset_quiet_R12: assert property (@(posedge clk)
        rst |=> (!out_valid && !err_valid && !byp_valid && cnt_glb_rd == '0));

endmodule

bind lane_seg_agen lseg_chk #(
    .LANES (LANES),
    .AW    (AW),
    .CNT_W (CNT_W)
) u_lseg_chk (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_pipe    (out_pipe),
    .out_latency (out_latency),
    .out_op      (out_op),
    .out_mask    (out_mask),
    .out_addr    (out_addr),
    .out_fault   (out_fault),
    .rdy_glb     (rdy_glb),
    .rdy_loc     (rdy_loc),
    .err_valid   (err_valid),
    .byp_valid   (byp_valid),
    .cpl_glb_rd  (cpl_glb_rd),
    .cpl_glb_wr  (cpl_glb_wr),
    .cnt_glb_rd  (cnt_glb_rd),
    .cnt_glb_wr  (cnt_glb_wr)
);

// File: tb/tb_lane_seg_agen.sv
module tb_lane_seg_agen;
    localparam int LANES  = 4;
    localparam int AW     = 32;
    localparam int CNT_W  = 8;
    localparam int CLK_HP = 5;
    localparam int NV     = 15;

    typedef struct packed {
        logic [2:0]   seg;
        logic [1:0]   op;
        logic [1:0]   szl;
        logic [2:0]   nr;
        logic [3:0]   mask;
        logic [127:0] addr;
        logic [127:0] eaddr;
        logic [3:0]   eflt;
        logic [1:0]   ekind;  // 0 request, 1 error, 2 bypass
        logic         epipe;
        logic [6:0]   elat;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        // global, sub-private remap, lane 2 misaligned (R2)
        '{3'd0, 2'd0, 2'd2, 3'd1, 4'hF, {32'h3C, 32'h13, 32'h5000, 32'h8},
          {32'h10FC, 32'h1053, 32'h5000, 32'h1020}, 4'b0100, 2'd0, 1'b0, 7'd1},
        // private store, lane 2 idle, lane 3 over size (R5, R1)
        '{3'd1, 2'd1, 2'd3, 3'd1, 4'b1011, {32'h40, 32'h7777, 32'h10, 32'h0},
          {32'h1058, 32'h7777, 32'h1018, 32'h1000}, 4'b1000, 2'd0, 1'b0, 7'd1},
        // spill (R3)
        '{3'd2, 2'd0, 2'd2, 3'd1, 4'hF, {32'h10, 32'hF, 32'h1, 32'h0},
          {32'h210C, 32'h20F8, 32'h2014, 32'h2000}, 4'b1000, 2'd0, 1'b0, 7'd1},
        // read-only edge (R4)
        '{3'd3, 2'd0, 2'd2, 3'd1, 4'hF, {32'h20, 32'h1D, 32'h1C, 32'h0},
          {32'h3020, 32'h301D, 32'h301C, 32'h3000}, 4'b1100, 2'd0, 1'b0, 7'd1},
        // group atomic (R6)
        '{3'd4, 2'd2, 2'd2, 3'd1, 4'b0101, {32'h40, 32'h30, 32'h20, 32'h10},
          {32'h40, 32'h30, 32'h20, 32'h10}, 4'b0000, 2'd0, 1'b1, 7'd24},
        // global atomic above private size (R6, R2)
        '{3'd0, 2'd2, 2'd2, 3'd1, 4'b0001, {32'h4, 32'h4, 32'h4, 32'h100},
          {32'h4, 32'h4, 32'h4, 32'h100}, 4'b0000, 2'd0, 1'b0, 7'd64},
        // group load (R6)
        '{3'd4, 2'd0, 2'd0, 3'd1, 4'hF, {32'h4, 32'h3, 32'h2, 32'h1},
          {32'h4, 32'h3, 32'h2, 32'h1}, 4'b0000, 2'd0, 1'b1, 7'd24},
        // errors (R7)
        '{3'd3, 2'd1, 2'd2, 3'd1, 4'hF, 128'h0, 128'h0, 4'b0, 2'd1, 1'b0, 7'd0},
        '{3'd1, 2'd2, 2'd2, 3'd1, 4'hF, 128'h0, 128'h0, 4'b0, 2'd1, 1'b0, 7'd0},
        '{3'd2, 2'd0, 2'd2, 3'd2, 4'hF, 128'h0, 128'h0, 4'b0, 2'd1, 1'b0, 7'd0},
        // bypass (R8)
        '{3'd5, 2'd0, 2'd2, 3'd1, 4'b1100, {32'hD, 32'hC, 32'hB, 32'hA},
          {96'h0, 32'hC}, 4'b0, 2'd2, 1'b0, 7'd0},
        '{3'd6, 2'd1, 2'd2, 3'd1, 4'b0000, {32'h1, 32'h2, 32'h3, 32'h4},
          128'h0, 4'b0, 2'd2, 1'b0, 7'd0},
        // errors (R7)
        '{3'd7, 2'd0, 2'd2, 3'd1, 4'hF, 128'h0, 128'h0, 4'b0, 2'd1, 1'b0, 7'd0},
        '{3'd5, 2'd1, 2'd2, 3'd1, 4'hF, 128'h0, 128'h0, 4'b0, 2'd1, 1'b0, 7'd0},
        // global, no lanes active (R1)
        '{3'd0, 2'd0, 2'd2, 3'd1, 4'h0, {32'h8, 32'h8, 32'h8, 32'h8},
          {32'h8, 32'h8, 32'h8, 32'h8}, 4'b0000, 2'd0, 1'b0, 7'd1}
    };

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_ready;
    logic [LANES-1:0] in_mask;
    logic [LANES*AW-1:0] in_addr;
    logic [2:0] in_seg;
    logic [1:0] in_op, in_size_log2;
    logic [2:0] in_nregs;
    logic [AW-1:0] priv_base, priv_size, spill_base, spill_size, spill_stride, ro_base, ro_size;
    logic out_valid, out_pipe;
    logic [6:0] out_latency;
    logic [1:0] out_op;
    logic [LANES-1:0] out_mask, out_fault;
    logic [LANES*AW-1:0] out_addr;
    logic rdy_glb, rdy_loc, err_valid, byp_valid;
    logic [AW-1:0] byp_addr;
    logic cpl_glb_rd, cpl_glb_wr, cpl_loc_rd, cpl_loc_wr;
    logic [CNT_W-1:0] cnt_glb_rd, cnt_glb_wr, cnt_loc_rd, cnt_loc_wr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #CLK_HP clk = ~clk;

    lane_seg_agen #(.LANES(LANES), .AW(AW), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_mask(in_mask), .in_addr(in_addr), .in_seg(in_seg), .in_op(in_op),
        .in_size_log2(in_size_log2), .in_nregs(in_nregs),
        .priv_base(priv_base), .priv_size(priv_size), .spill_base(spill_base),
        .spill_size(spill_size), .spill_stride(spill_stride), .ro_base(ro_base),
        .ro_size(ro_size), .out_valid(out_valid), .out_pipe(out_pipe),
        .out_latency(out_latency), .out_op(out_op), .out_mask(out_mask),
        .out_addr(out_addr), .out_fault(out_fault), .rdy_glb(rdy_glb),
        .rdy_loc(rdy_loc), .err_valid(err_valid), .byp_valid(byp_valid),
        .byp_addr(byp_addr), .cpl_glb_rd(cpl_glb_rd), .cpl_glb_wr(cpl_glb_wr),
        .cpl_loc_rd(cpl_loc_rd), .cpl_loc_wr(cpl_loc_wr),
        .cnt_glb_rd(cnt_glb_rd), .cnt_glb_wr(cnt_glb_wr),
        .cnt_loc_rd(cnt_loc_rd), .cnt_loc_wr(cnt_loc_wr)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] seg, input logic [1:0] op,
                         input logic [1:0] szl, input logic [2:0] nr,
                         input logic [3:0] mask, input logic [127:0] addr);
        in_valid     = 1'b1;
        in_seg       = seg;
        in_op        = op;
        in_size_log2 = szl;
        in_nregs     = nr;
        in_mask      = mask;
        in_addr      = addr;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0; in_mask = '0; in_addr = '0; in_seg = '0; in_op = '0;
        in_size_log2 = '0; in_nregs = 3'd1;
        priv_base = 32'h1000; priv_size = 32'h40;
        spill_base = 32'h2000; spill_size = 32'h10; spill_stride = 32'h10;
        ro_base = 32'h3000; ro_size = 32'h20;
        rdy_glb = 1'b0; rdy_loc = 1'b0;
        cpl_glb_rd = 0; cpl_glb_wr = 0; cpl_loc_rd = 0; cpl_loc_wr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        chk("R12", "out_valid", 128'(out_valid), 128'd0);
        chk("R12", "err/byp", 128'({err_valid, byp_valid}), 128'd0);
        chk("R12", "in_ready", 128'(in_ready), 128'd1);
        chk("R12", "counters", 128'({cnt_glb_rd, cnt_glb_wr, cnt_loc_rd, cnt_loc_wr}), 128'd0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            drive(VEC[v].seg, VEC[v].op, VEC[v].szl, VEC[v].nr, VEC[v].mask, VEC[v].addr);
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            case (VEC[v].ekind)
                2'd0: begin
                    chk("R10", $sformatf("v%0d out_valid", v), 128'(out_valid), 128'd1);
                    chk("R6", $sformatf("v%0d pipe", v), 128'(out_pipe), 128'(VEC[v].epipe));
                    chk("R6", $sformatf("v%0d latency", v), 128'(out_latency), 128'(VEC[v].elat));
                    chk("R2_R3_R4_R5", $sformatf("v%0d addr", v), out_addr, VEC[v].eaddr);
                    chk("R1", $sformatf("v%0d fault", v), 128'(out_fault), 128'(VEC[v].eflt));
                    chk("R1", $sformatf("v%0d mask", v), 128'(out_mask), 128'(VEC[v].mask));
                end
                2'd1: begin
                    chk("R7", $sformatf("v%0d err", v), 128'(err_valid), 128'd1);
                    chk("R7", $sformatf("v%0d no req", v), 128'({out_valid, byp_valid}), 128'd0);
                end
                default: begin
                    chk("R8", $sformatf("v%0d byp", v), 128'(byp_valid), 128'd1);
                    chk("R8", $sformatf("v%0d byp_addr", v), 128'(byp_addr), VEC[v].eaddr);
                    chk("R8", $sformatf("v%0d no req", v), 128'({out_valid, err_valid}), 128'd0);
                end
            endcase
            rdy_glb = 1'b1; rdy_loc = 1'b1;
            @(posedge clk);
            @(negedge clk);
            rdy_glb = 1'b0; rdy_loc = 1'b0;
            chk("R7_R8", $sformatf("v%0d drained", v), 128'({out_valid, err_valid, byp_valid}), 128'd0);
        end

        // R11 totals from the table
        chk("R11", "glb_rd", 128'(cnt_glb_rd), 128'd5);
        chk("R11", "glb_wr", 128'(cnt_glb_wr), 128'd2);
        chk("R11", "loc_rd", 128'(cnt_loc_rd), 128'd2);
        chk("R11", "loc_wr", 128'(cnt_loc_wr), 128'd1);
        cpl_glb_rd = 1'b1; cpl_loc_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cpl_glb_rd = 1'b0; cpl_loc_wr = 1'b0;
        chk("R11", "glb_rd after cpl", 128'(cnt_glb_rd), 128'd4);
        chk("R11", "loc_wr after cpl", 128'(cnt_loc_wr), 128'd0);

        // R9: local request held while only the global queue is ready
        rdy_glb = 1'b1; rdy_loc = 1'b0;
        drive(3'd4, 2'd0, 2'd2, 3'd1, 4'hF, {32'h44, 32'h33, 32'h22, 32'h11});
        @(posedge clk);
        @(negedge clk);
        drive(3'd0, 2'd0, 2'd2, 3'd1, 4'hF, {32'h200, 32'h200, 32'h200, 32'h200});
        chk("R10", "stalled in_ready", 128'(in_ready), 128'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R9", "held valid", 128'(out_valid), 128'd1);
        chk("R9", "held pipe", 128'(out_pipe), 128'd1);
        chk("R9", "held addr", out_addr, {32'h44, 32'h33, 32'h22, 32'h11});
        // R10: drain and accept in the same cycle
        rdy_loc = 1'b1;
        #1;
        chk("R10", "in_ready on consume", 128'(in_ready), 128'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        rdy_loc = 1'b0;
        chk("R10", "next valid", 128'(out_valid), 128'd1);
        chk("R10", "next pipe", 128'(out_pipe), 128'd0);
        chk("R10", "next addr", out_addr, {32'h200, 32'h200, 32'h200, 32'h200});
        chk("R11", "loc_rd after hold", 128'(cnt_loc_rd), 128'd3);
        @(posedge clk);
        @(negedge clk);
        rdy_glb = 1'b0;
        chk("R11", "glb_rd final", 128'(cnt_glb_rd), 128'd5);
        chk("R9", "drained", 128'(out_valid), 128'd0);

        finish_run();
    end
endmodule